// File: doc/BRIEF.md
# Colour Palette Register Interface

This block is the host side of an 8-bit-per-pixel colour lookup unit. It keeps a 256-entry palette, where each entry holds a red, a green and a blue 8-bit component. It also keeps four control registers: a plane read mask, a blink mask, a command register and a test register. The host reaches all of them through three ports on one request channel. The address port selects a control register and also positions the palette pointer. The control port reads or writes the selected control register. The palette port walks the palette one component after another.

The host bus has two forms, chosen by a static pin. In packed form, each 32-bit palette access moves four consecutive components. In byte-lane form, each access moves one component, carried in the top byte. A combinational lookup path turns a pixel index into a 24-bit colour. It masks the index with the read mask and outputs the colour only while the palette-enable command bit is set.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A read yields one response on `rsp_valid` in the next cycle, and that response is held until `rsp_ready` is seen high. While a response is pending, `req_ready` stays low, so no further request is taken. Writes yield no response.

Top module: `ramdac_regif`

## Requirements
- R1: After reset the palette, blink mask, command register, test register, address register and pointer are all zero, and the read mask is 0xFF.
- R2: The address register holds a control selector. The selector values are 4 for the read mask, 5 for the blink mask, 6 for the command register and 7 for the test register. A control-port write to any other selector changes nothing, and a control-port read of any other selector returns zero.
- R3: Address-port and control-port writes take their byte from bits 7:0 in packed form (`packed_mode`=1) and from bits 31:24 in byte-lane form. Reads from these ports return the byte copied onto all four lanes. A reply on `req_port`=3 is zero, and a write there has no effect.
- R4: Writing value N to the address port sets the palette pointer to entry N, red component. Palette-port accesses then step through red, green, blue, then the next entry's red.
- R5: In packed form a palette access moves four consecutive components, with the lowest-index component in bits 31:24. The pointer then advances by four.
- R6: In byte-lane form a palette access moves one component in bits 31:24 and advances the pointer by one. Bits 23:0 are ignored on writes and read as zero.
- R7: Palette-port reads advance the pointer exactly as writes do.
- R8: The pointer wraps from the blue component of entry 255 to the red component of entry 0. In packed form the four components of one access wrap the same way.
- R9: `pix_rgb` is {red, green, blue} of entry (`pix_index` AND read mask) while command bit 6 is set, and zero while that bit is clear.
- R10: Port codes on `req_port` are 0 address, 1 control, 2 palette and 3 unused. A read request gives `rsp_valid` one cycle after acceptance. While `rsp_valid` is high and `rsp_ready` is low, `rsp_rdata` holds steady and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| packed_mode | input | 1 | Static bus form: 1 packed, 0 byte-lane |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 write, 0 read |
| req_port | input | 2 | Port code: 0 address, 1 control, 2 palette, 3 unused |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 32 | Read response data |
| pix_index | input | 8 | Pixel value to look up |
| pix_rgb | output | 24 | Looked-up colour {red, green, blue} |

## Verification
A wrong pointer or phase shows up at the very next palette read, which returns the wrong component, or a right component in the wrong byte lane. A wrap error shows up only after the full 768 components have been crossed, so the bench drives the pointer across that boundary on purpose. A wrong control register or palette byte shows up at once on `pix_rgb` for any pixel index that reaches it through the mask, because that path has no register stage. Handshake faults show up in the cycle of the stall, as a changed response or a raised `req_ready`.

// File: rtl/ramdac_pkg.sv
package ramdac_pkg;
  typedef enum logic [1:0] {
    PORT_ADDR = 2'd0,
    PORT_CTRL = 2'd1,
    PORT_PAL  = 2'd2,
    PORT_NONE = 2'd3
  } port_e;

  localparam logic [7:0] SEL_RMASK = 8'd4;
  localparam logic [7:0] SEL_BLINK = 8'd5;
  localparam logic [7:0] SEL_CMD   = 8'd6;
  localparam logic [7:0] SEL_TEST  = 8'd7;
  localparam int         CMD_PAL_EN_BIT = 6;
  localparam int         COMP_W    = 8;
  localparam int         NCOMP     = 3;
endpackage

// File: rtl/ramdac_ctrl_regs.sv
module ramdac_ctrl_regs
  import ramdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        sel,
  input  logic [COMP_W-1:0] wbyte,
  output logic [COMP_W-1:0] rbyte,
  output logic [COMP_W-1:0] rmask,
  output logic [COMP_W-1:0] cmd
);
  logic [COMP_W-1:0] blink_q, test_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rmask   <= '1;
      blink_q <= '0;
      cmd     <= '0;
      test_q  <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_RMASK: rmask   <= wbyte;
        SEL_BLINK: blink_q <= wbyte;
        SEL_CMD:   cmd     <= wbyte;
        SEL_TEST:  test_q  <= wbyte;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_RMASK: rbyte = rmask;
      SEL_BLINK: rbyte = blink_q;
      SEL_CMD:   rbyte = cmd;
      SEL_TEST:  rbyte = test_q;
      default:   rbyte = '0;
    endcase
  end

  // R2
  unsel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel < SEL_RMASK || sel > SEL_TEST)) |=>
      ($stable(rmask) && $stable(blink_q) && $stable(cmd) && $stable(test_q)));
endmodule

// File: rtl/ramdac_palette.sv
module ramdac_palette
  import ramdac_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int LANES   = 4,
  localparam int TOTAL  = ENTRIES * NCOMP,
  localparam int PTR_W  = $clog2(TOTAL),
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int BUS_W  = LANES * COMP_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    packed_mode,
  input  logic                    ptr_load,
  input  logic [IDX_W-1:0]        ptr_entry,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [BUS_W-1:0]        wdata,
  output logic [BUS_W-1:0]        rdata,
  input  logic [IDX_W-1:0]        pix_index,
  input  logic [IDX_W-1:0]        pix_mask,
  input  logic                    pix_en,
  output logic [NCOMP*COMP_W-1:0] pix_rgb
);
  logic [COMP_W-1:0] mem [TOTAL];
  logic [PTR_W-1:0]  ptr;
  logic [PTR_W-1:0]  lane_ptr [LANES];

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p, input int k);
    logic [PTR_W:0] s;
    s = {1'b0, p} + (PTR_W+1)'(k);
    if (s >= (PTR_W+1)'(TOTAL)) s = s - (PTR_W+1)'(TOTAL);
    return s[PTR_W-1:0];
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_ptr[l] = step(ptr, l);
    if (l == 0) begin : g_top
      assign rdata[BUS_W-1 -: COMP_W] = mem[lane_ptr[0]];
    end else begin : g_rest
      assign rdata[BUS_W-1-l*COMP_W -: COMP_W] = packed_mode ? mem[lane_ptr[l]] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++) mem[i] <= '0;
    end else if (wr_en) begin
      if (packed_mode) begin
        for (int l = 0; l < LANES; l++)
          mem[lane_ptr[l]] <= wdata[BUS_W-1-l*COMP_W -: COMP_W];
      end else begin
        mem[ptr] <= wdata[BUS_W-1 -: COMP_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                ptr <= '0;
    else if (ptr_load)         ptr <= PTR_W'(ptr_entry) * PTR_W'(NCOMP);
    else if (wr_en || rd_en)   ptr <= step(ptr, packed_mode ? LANES : 1);
  end

  logic [IDX_W-1:0] pix_sel;
  logic [PTR_W-1:0] pix_base;
  assign pix_sel  = pix_index & pix_mask;
  assign pix_base = PTR_W'(pix_sel) * PTR_W'(NCOMP);
  assign pix_rgb  = pix_en ? {mem[pix_base], mem[pix_base + PTR_W'(1)], mem[pix_base + PTR_W'(2)]}
                           : '0;

  // R4
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr < PTR_W'(TOTAL));

  // R6
  byte_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!packed_mode && (wr_en || rd_en) && !ptr_load && ptr != PTR_W'(TOTAL-1)) |=>
      ptr == $past(ptr) + PTR_W'(1));

  // R8
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!packed_mode && (wr_en || rd_en) && !ptr_load && ptr == PTR_W'(TOTAL-1)) |=>
      ptr == '0);
endmodule

// File: rtl/ramdac_regif.sv
module ramdac_regif
  import ramdac_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int BUS_W   = 32,
  localparam int LANES  = BUS_W / COMP_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    packed_mode,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [1:0]              req_port,
  input  logic [BUS_W-1:0]        req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [BUS_W-1:0]        rsp_rdata,
  input  logic [IDX_W-1:0]        pix_index,
  output logic [NCOMP*COMP_W-1:0] pix_rgb
);
  logic              fire;
  port_e             port;
  logic [7:0]        addr_q;
  logic [COMP_W-1:0] wbyte, ctrl_rbyte, rmask, cmd;
  logic [BUS_W-1:0]  pal_rdata, rd_mux;

  assign req_ready = !rsp_valid;
  assign fire      = req_valid && req_ready;
  assign port      = port_e'(req_port);
  assign wbyte     = packed_mode ? req_wdata[COMP_W-1:0] : req_wdata[BUS_W-1 -: COMP_W];

  always_ff @(posedge clk) begin
    if (!rst_n)                                   addr_q <= '0;
    else if (fire && req_write && port == PORT_ADDR) addr_q <= wbyte;
  end

  ramdac_ctrl_regs u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (fire && req_write && port == PORT_CTRL),
    .sel   (addr_q),
    .wbyte (wbyte),
    .rbyte (ctrl_rbyte),
    .rmask (rmask),
    .cmd   (cmd)
  );

  ramdac_palette #(.ENTRIES(ENTRIES), .LANES(LANES)) u_pal (
    .clk         (clk),
    .rst_n       (rst_n),
    .packed_mode (packed_mode),
    .ptr_load    (fire && req_write && port == PORT_ADDR),
    .ptr_entry   (wbyte[IDX_W-1:0]),
    .wr_en       (fire && req_write && port == PORT_PAL),
    .rd_en       (fire && !req_write && port == PORT_PAL),
    .wdata       (req_wdata),
    .rdata       (pal_rdata),
    .pix_index   (pix_index),
    .pix_mask    (rmask[IDX_W-1:0]),
    .pix_en      (cmd[CMD_PAL_EN_BIT]),
    .pix_rgb     (pix_rgb)
  );

  always_comb begin
    case (port)
      PORT_ADDR: rd_mux = {LANES{addr_q}};
      PORT_CTRL: rd_mux = {LANES{ctrl_rbyte}};
      PORT_PAL:  rd_mux = pal_rdata;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (fire && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R10
  read_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_write) |=> rsp_valid);

  // R9
  pix_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_write && port == PORT_CTRL && addr_q == SEL_CMD && !wbyte[CMD_PAL_EN_BIT])
      |=> pix_rgb == '0);
endmodule

// File: tb/sim_ramdac_regif.sv
module sim_ramdac_regif;
  localparam int TOTAL = 768;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        packed_mode = 1;
  logic        req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [1:0]  req_port = 0;
  logic [31:0] req_wdata = 0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [7:0]  pix_index = 0;
  logic [23:0] pix_rgb;

  int checks = 0, failures = 0;

  logic [7:0] mc [TOTAL];
  int         mptr;
  logic [7:0] maddr, mmask, mblink, mcmd, mtest;

  always #10 clk = ~clk;

  ramdac_regif u0 (
    .clk(clk), .rst_n(rst_n), .packed_mode(packed_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_port(req_port), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pix_index(pix_index), .pix_rgb(pix_rgb)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] lane_byte(input logic [31:0] d);
    return packed_mode ? d[7:0] : d[31:24];
  endfunction

  function automatic logic [7:0] ctrl_val(input logic [7:0] a);
    case (a)
      8'd4: return mmask;
      8'd5: return mblink;
      8'd6: return mcmd;
      8'd7: return mtest;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [23:0] exp_pix(input logic [7:0] p);
    int b;
    b = int'(p & mmask) * 3;
    return mcmd[6] ? {mc[b], mc[b+1], mc[b+2]} : 24'h0;
  endfunction

  // model update; returns expected read data
  task automatic model(input logic [1:0] port, input bit wr, input logic [31:0] d,
                       output logic [31:0] e);
    e = 32'h0;
    case (port)
      2'd0: if (wr) begin maddr = lane_byte(d); mptr = int'(maddr) * 3; end
            else e = {4{maddr}};
      2'd1: if (wr) begin
              case (maddr)
                8'd4: mmask = lane_byte(d);
                8'd5: mblink = lane_byte(d);
                8'd6: mcmd = lane_byte(d);
                8'd7: mtest = lane_byte(d);
                default: ;
              endcase
            end else e = {4{ctrl_val(maddr)}};
      2'd2: begin
              if (packed_mode) begin
                for (int l = 0; l < 4; l++) begin
                  if (wr) mc[(mptr + l) % TOTAL] = d[31-8*l -: 8];
                  else e[31-8*l -: 8] = mc[(mptr + l) % TOTAL];
                end
                mptr = (mptr + 4) % TOTAL;
              end else begin
                if (wr) mc[mptr] = d[31:24];
                else e = {mc[mptr], 24'h0};
                mptr = (mptr + 1) % TOTAL;
              end
            end
      default: ;
    endcase
  endtask

  task automatic acc(input logic [1:0] port, input bit wr, input logic [31:0] d,
                     output logic [31:0] r, output logic [31:0] e);
    model(port, wr, d, e);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_port = port; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    r = rsp_rdata;
    if (!wr && !rsp_valid) check("R10 rsp_valid after read", {31'h0, rsp_valid}, 32'h1);
  endtask

  task automatic wr(input logic [1:0] port, input logic [31:0] d);
    logic [31:0] r, e;
    acc(port, 1'b1, d, r, e);
  endtask

  task automatic rd_chk(input string req, input logic [1:0] port);
    logic [31:0] r, e;
    acc(port, 1'b0, 32'h0, r, e);
    check(req, r, e);
  endtask

  task automatic pix_chk(input string req, input logic [7:0] p);
    @(negedge clk);
    pix_index = p;
    #1;
    check(req, {8'h0, pix_rgb}, {8'h0, exp_pix(p)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r, e, held;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < TOTAL; i++) mc[i] = 8'h0;
    mptr = 0; maddr = 0; mmask = 8'hFF; mblink = 0; mcmd = 0; mtest = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check("R1 req_ready", {31'h0, req_ready}, 32'h1);
    check("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    rd_chk("R1 address reads zero", 2'd0);
    pix_chk("R1 pixel off at reset", 8'h37);
    for (int s = 4; s < 8; s++) begin
      wr(2'd0, 32'(s) * 32'h01010101);
      rd_chk("R1 control reset value", 2'd1);
    end
    wr(2'd0, 32'h0);
    rd_chk("R1 palette zero (packed)", 2'd2);

    // R5 packed fill of whole palette, random
    wr(2'd0, 32'h0);
    for (int i = 0; i < 192; i++) wr(2'd2, $urandom);
    // R8 after 192 accesses the pointer is back at entry 0 red
    rd_chk("R8 packed wrap to entry 0", 2'd2);
    wr(2'd0, 32'h0);
    for (int i = 0; i < 192; i++) rd_chk("R5 packed readback", 2'd2);

    // R4 start mid-palette, unaligned packed read
    wr(2'd0, 32'h0000_0055);
    rd_chk("R4 entry 0x55 red first", 2'd2);
    rd_chk("R7 read advanced pointer", 2'd2);

    // R6 byte-lane form
    @(negedge clk); packed_mode = 0;
    wr(2'd0, 32'h1000_0000);
    wr(2'd2, 32'hA1FF_FFFF);
    wr(2'd2, 32'hB2FF_FFFF);
    wr(2'd2, 32'hC3FF_FFFF);
    wr(2'd0, 32'h1000_0000);
    rd_chk("R6 byte read red", 2'd2);
    rd_chk("R6 byte read green", 2'd2);
    rd_chk("R6 byte read blue", 2'd2);
    rd_chk("R4 next entry red", 2'd2);
    for (int i = 0; i < 20; i++) begin
      if ($urandom_range(1, 0) == 1) wr(2'd2, $urandom);
      else rd_chk("R7 random byte access", 2'd2);
    end

    // R8 byte-lane wrap
    wr(2'd0, 32'hFF00_0000);
    wr(2'd2, 32'h1100_0000);
    wr(2'd2, 32'h2200_0000);
    wr(2'd2, 32'h3300_0000);
    wr(2'd2, 32'h4400_0000);
    wr(2'd0, 32'h0000_0000);
    rd_chk("R8 byte wrap wrote entry 0 red", 2'd2);
    wr(2'd0, 32'hFF00_0000);
    rd_chk("R8 entry 255 red", 2'd2);

    // R3 lane choice in byte-lane form: top byte used
    wr(2'd0, 32'h0600_0004);
    rd_chk("R3 byte-lane selector from top byte", 2'd0);
    wr(2'd1, 32'h4300_0000);
    rd_chk("R3 command from top byte", 2'd1);

    // R3 lane choice in packed form: low byte used
    @(negedge clk); packed_mode = 1;
    wr(2'd0, 32'h0000_0006);
    wr(2'd1, 32'h0000_0040);
    rd_chk("R3 packed command from low byte", 2'd1);
    wr(2'd1, 32'h4343_4343);
    rd_chk("R3 replicated command", 2'd1);

    // R2 unselected register
    wr(2'd0, 32'h0202_0202);
    wr(2'd1, 32'h5555_5555);
    rd_chk("R2 unselected reads zero", 2'd1);
    wr(2'd0, 32'h0505_0505);
    wr(2'd1, 32'h0F0F_0F0F);
    rd_chk("R2 blink mask", 2'd1);
    wr(2'd0, 32'h0707_0707);
    wr(2'd1, 32'h0101_0101);
    rd_chk("R2 test register", 2'd1);
    wr(2'd0, 32'h0606_0606);
    rd_chk("R2 command unchanged", 2'd1);

    // R3 unused port
    wr(2'd3, 32'hFFFF_FFFF);
    rd_chk("R3 unused port reads zero", 2'd3);
    wr(2'd0, 32'h0000_0004);
    rd_chk("R3 unused write left mask", 2'd1);

    // R9 pixel lookup with masks
    for (int i = 0; i < 16; i++) pix_chk("R9 pixel full mask", 8'($urandom));
    wr(2'd0, 32'h0000_0004);
    wr(2'd1, 32'h0000_000F);
    for (int i = 0; i < 16; i++) pix_chk("R9 pixel masked", 8'($urandom));
    wr(2'd0, 32'h0000_0006);
    wr(2'd1, 32'h0000_0003);
    pix_chk("R9 palette disabled", 8'h0A);

    // R10 back-pressure
    wr(2'd0, 32'h0000_0004);
    rsp_ready = 0;
    acc(2'd1, 1'b0, 32'h0, r, e);
    check("R10 stalled response data", r, e);
    held = r;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10 valid held", {31'h0, rsp_valid}, 32'h1);
      check("R10 ready low", {31'h0, req_ready}, 32'h0);
      check("R10 data held", rsp_rdata, held);
    end
    rsp_ready = 1;
    @(negedge clk);
    check("R10 response taken", {31'h0, rsp_valid}, 32'h0);
    check("R10 ready back", {31'h0, req_ready}, 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule